// File: doc/BRIEF.md
# Spread-Spectrum Step Sequencer

This block drives the frequency-offset index of a PLL feedback divider so that the synthesized clock sweeps slowly around its nominal value, which spreads its spectral energy. The signed index climbs one step at a time up to a programmed upper limit. It then falls one step at a time to a programmed lower limit and climbs again. This traces a continuous triangle. Each step is held for a programmed number of timebase ticks, and the ticks come from an external divider.

The upper limit is a plain positive count. The lower limit is programmed as a two's-complement code whose negation gives the magnitude of the excursion below nominal. A parameter can switch this to a plain magnitude. When the enable input is low, the index returns to nominal and all sequencing state is cleared. Every restart therefore begins at zero, heading upward, with a full dwell period ahead of it.

Top module: `ssc_step_seq`

## Requirements
- R1: While reset is held, and at the first check after reset is released, `offset_idx` is 0.
- R2: With `ss_en` low at a clock edge, `offset_idx` is 0 after that edge and the dwell count is cleared. After re-enabling, the first move is upward and comes only after a full dwell period of ticks.
- R3: With `dwell_code` = D in 1..63, `offset_idx` moves by exactly one on every D-th tick counted from enable, and at no other tick.
- R4: A `dwell_code` of 0 behaves as a dwell of one tick, so the index moves on every tick.
- R5: The index rises until it equals `up_steps` (an unsigned value, 0..15), and the next move is downward.
- R6: `dn_code` is a 4-bit two's-complement code. The lower limit is -((16 - code) mod 16), so 1111 gives -1, 1110 gives -2, 1001 gives -7, 1000 gives -8 and 0000 gives 0. The index falls to this limit and the next move is upward.
- R7: A clock edge with `tick` low leaves `offset_idx` unchanged.
- R8: With both limits 0, the index stays at 0. With one limit 0, the triangle folds back at nominal on that side.
- R9: While enabled, `offset_idx` changes by at most one between consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ss_en | input | 1 | Spreading enable; low forces nominal and clears state |
| up_steps | input | 4 | Upper limit of the index, unsigned |
| dn_code | input | 4 | Lower limit, two's-complement code of its magnitude |
| dwell_code | input | 6 | Ticks per step; 0 is treated as 1 |
| tick | input | 1 | Timebase tick, one cycle wide |
| offset_idx | output | 5 | Signed frequency-offset index |

## Verification
The index is registered, so a tick that completes a dwell period shows on `offset_idx` right after the clock edge at which that tick is sampled. Clearing on a low enable also takes effect at that same edge. The bench drives `tick` and the configuration on falling edges. At each falling edge it first compares `offset_idx` with a closed-form triangle, evaluated at floor(ticks-so-far / dwell). The tick count includes only ticks whose rising edge has already passed. Each check therefore sits exactly one half period after the edge that is meant to produce the value.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } ssc_dir_e;

   function automatic int unsigned ssc_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ssc_dn_decode.sv
module ssc_dn_decode #(
   parameter int unsigned DN_W        = 4,
   parameter bit          DN_TWOS_CPL = 1'b1
) (
   input  logic [DN_W-1:0] dn_code,
   output logic [DN_W-1:0] dn_mag
);
   generate
      if (DN_TWOS_CPL) begin : g_twos
         // magnitude of a negative two's-complement code; all-zero maps to 0
         always_comb dn_mag = (~dn_code) + DN_W'(1);
      end else begin : g_plain
         always_comb dn_mag = dn_code;
      end
   endgenerate
endmodule

// File: rtl/ssc_dwell_timer.sv
module ssc_dwell_timer #(
   parameter int unsigned DWELL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               tick,
   input  logic [DWELL_W-1:0] dwell_code,
   output logic               step
);
   logic [DWELL_W-1:0] cnt_q;
   logic [DWELL_W-1:0] last_cnt;
   logic               at_end;

   // a zero dwell collapses to a single tick
   always_comb begin
      last_cnt = (dwell_code == '0) ? '0 : dwell_code - DWELL_W'(1);
      at_end   = (cnt_q >= last_cnt);
      step     = en & tick & at_end;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= at_end ? '0 : cnt_q + DWELL_W'(1);
      end
   end

   // R2: a disabled cycle leaves the dwell count cleared
   p_dwell_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0));

   // R3: a tick that does not finish the period advances the count by one
   p_dwell_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && !step) |=> (cnt_q == $past(cnt_q) + DWELL_W'(1)));

   // R7: without a tick the count holds
   p_dwell_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/ssc_index_ctrl.sv
module ssc_index_ctrl
   import ssc_pkg::*;
#(
   parameter int unsigned UP_W  = 4,
   parameter int unsigned MAG_W = 4,
   parameter int unsigned IDX_W = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    step,
   input  logic [UP_W-1:0]         up_lim,
   input  logic [MAG_W-1:0]        dn_mag,
   output logic signed [IDX_W-1:0] idx
);
   localparam logic signed [IDX_W-1:0] ONE = IDX_W'(1);

   logic signed [IDX_W-1:0] hi_lim, lo_lim, idx_q, idx_nxt;
   ssc_dir_e                dir_q, dir_nxt;

   always_comb begin
      hi_lim = $signed({{(IDX_W-UP_W){1'b0}}, up_lim});
      lo_lim = -$signed({{(IDX_W-MAG_W){1'b0}}, dn_mag});
   end

   // move in the current direction; at a limit turn round; with no room hold
   always_comb begin
      idx_nxt = idx_q;
      dir_nxt = dir_q;
      if (dir_q == DIR_UP) begin
         if (idx_q < hi_lim) begin
            idx_nxt = idx_q + ONE;
         end else if (idx_q > lo_lim) begin
            idx_nxt = idx_q - ONE;
            dir_nxt = DIR_DN;
         end
      end else begin
         if (idx_q > lo_lim) begin
            idx_nxt = idx_q - ONE;
         end else if (idx_q < hi_lim) begin
            idx_nxt = idx_q + ONE;
            dir_nxt = DIR_UP;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         idx_q <= '0;
         dir_q <= DIR_UP;
      end else if (step) begin
         idx_q <= idx_nxt;
         dir_q <= dir_nxt;
      end
   end

   assign idx = idx_q;

   // R2: disabled means nominal
   p_idx_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (idx == '0));

   // R7: no step, no movement
   p_idx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !step) |=> $stable(idx));

   // R9: single-unit moves
   p_idx_unit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((idx == $past(idx)) || (idx == $past(idx) + ONE) ||
              (idx == $past(idx) - ONE)));

   // R5: never steps above the upper limit
   p_idx_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && (idx <= hi_lim)) |=> (idx <= $past(hi_lim)));

   // R6: never steps below the lower limit
   p_idx_lower_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && (idx >= lo_lim)) |=> (idx >= $past(lo_lim)));
endmodule

// File: rtl/ssc_step_seq.sv
module ssc_step_seq
   import ssc_pkg::*;
#(
   parameter int unsigned UP_W        = 4,
   parameter int unsigned DN_W        = 4,
   parameter int unsigned DWELL_W     = 6,
   parameter bit          DN_TWOS_CPL = 1'b1
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       ss_en,
   input  logic [UP_W-1:0]                            up_steps,
   input  logic [DN_W-1:0]                            dn_code,
   input  logic [DWELL_W-1:0]                         dwell_code,
   input  logic                                       tick,
   output logic signed [((UP_W > DN_W) ? UP_W : DN_W):0] offset_idx
);
   localparam int unsigned MAG_W = DN_W;
   localparam int unsigned IDX_W = ssc_max(UP_W, MAG_W) + 1;

   generate
      if (UP_W < 1 || UP_W > 16) begin : g_bad_up
         $error("ssc_step_seq: UP_W out of range");
      end
      if (DN_W < 2 || DN_W > 16) begin : g_bad_dn
         $error("ssc_step_seq: DN_W out of range");
      end
      if (DWELL_W < 1 || DWELL_W > 24) begin : g_bad_dwell
         $error("ssc_step_seq: DWELL_W out of range");
      end
   endgenerate

   logic             step;
   logic [MAG_W-1:0] dn_mag;

   ssc_dn_decode #(
      .DN_W        (DN_W),
      .DN_TWOS_CPL (DN_TWOS_CPL)
   ) dec_i (
      .dn_code (dn_code),
      .dn_mag  (dn_mag)
   );

   ssc_dwell_timer #(
      .DWELL_W (DWELL_W)
   ) tmr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (ss_en),
      .tick       (tick),
      .dwell_code (dwell_code),
      .step       (step)
   );

   ssc_index_ctrl #(
      .UP_W  (UP_W),
      .MAG_W (MAG_W),
      .IDX_W (IDX_W)
   ) idx_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ss_en),
      .step   (step),
      .up_lim (up_steps),
      .dn_mag (dn_mag),
      .idx    (offset_idx)
   );

   // R7: an edge without a tick never moves the output
   p_top_notick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_en && !tick) |=> $stable(offset_idx));
endmodule

// File: tb/ssc_step_seq_tb_top.sv
module ssc_step_seq_tb_top;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ss_en = 1'b0;
   logic [3:0]        up_steps = '0;
   logic [3:0]        dn_code = '0;
   logic [5:0]        dwell_code = '0;
   logic              tick = 1'b0;
   logic signed [4:0] offset_idx;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ssc_step_seq dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ss_en      (ss_en),
      .up_steps   (up_steps),
      .dn_code    (dn_code),
      .dwell_code (dwell_code),
      .tick       (tick),
      .offset_idx (offset_idx)
   );

   // triangle value after k steps, starting at 0 and rising
   function automatic int tri_val(int k, int u, int d);
      int per, p;
      if (u + d == 0) return 0;
      per = 2 * (u + d);
      p = k % per;
      if (p <= u) return p;
      if (p <= 2 * u + d) return u - (p - u);
      return -d + (p - (2 * u + d));
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: offset_idx=%0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // one disabled edge, then gap-spaced ticks compared against the triangle
   task automatic run_seq(string req, int u, int dc, int dw, int n_cyc, int gap);
      int dmag, eff, t, prev;
      dmag = (16 - dc) % 16;
      eff  = (dw == 0) ? 1 : dw;
      @(negedge clk);
      ss_en = 1'b0; tick = 1'b1;
      up_steps = 4'(u); dn_code = 4'(dc); dwell_code = 6'(dw);
      @(negedge clk);
      check("R2 disable", int'(offset_idx), 0);
      ss_en = 1'b1; tick = 1'b0;
      t = 0; prev = 0;
      for (int c = 0; c < n_cyc; c++) begin
         @(negedge clk);
         check(req, int'(offset_idx), tri_val(t / eff, u, dmag));
         check("R9 unit step", ((int'(offset_idx) - prev) <= 1 &&
                                (int'(offset_idx) - prev) >= -1) ? 1 : 0, 1);
         prev = int'(offset_idx);
         tick = ((c % gap) == 0);
         if (tick) t++;
      end
      @(negedge clk);
      tick = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, cycle %0d expected < 190000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", int'(offset_idx), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", int'(offset_idx), 0);

      // R5 R6 R8: every limit pair with a single-tick dwell
      for (int u = 0; u < 16; u++) begin
         for (int dc = 0; dc < 16; dc++) begin
            run_seq("R5 R6 R8 limits", u, dc, 1, 2 * (u + (16 - dc) % 16) + 4, 1);
         end
      end

      // R3 R4: every dwell code, including zero
      for (int dw = 0; dw < 64; dw++) begin
         run_seq("R3 R4 dwell", 2, 15, dw, 3 * ((dw == 0) ? 1 : dw) + 3, 1);
      end

      // R7: sparse ticks
      run_seq("R7 sparse ticks", 3, 14, 2, 60, 3);
      run_seq("R7 sparse ticks", 1, 8, 1, 50, 4);

      // R2: abandon a run mid-dwell, restart must begin a full dwell fresh
      run_seq("R2 partial", 4, 12, 5, 8, 1);
      run_seq("R2 restart", 4, 12, 5, 40, 1);

      // R6: decode spot values at wider dwell
      run_seq("R6 code 1001", 0, 9, 3, 50, 1);
      run_seq("R6 code 1000", 5, 8, 2, 60, 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule